// File: doc/BRIEF.md
# VME Slave Main-Memory Window Decoder

This block decides, for each access that a VMEbus slave interface presents, whether local main memory claims it. The 32-bit address must fall in a selected 256 MB page and, within that page, inside an inclusive interval whose two bounds have 4 KB granularity. The address modifier must be one of four extended (A32) codes. Each code carries its own permission: disabled, read only, or read and write. A write that lands in the window under a read-only code is refused and reported.

Six 8-bit configuration registers are written and read through a plain local register port. One register holds the page nibble. Two hold the lower bound, split high and low, and two hold the upper bound, split the same way. One holds four 2-bit permission fields. Everything clears at reset, so memory stays unreachable until software opens the window.

Access inputs are sampled on the clock edge where the access strobe is high. The select output and the violation flag are registered, so each is valid one cycle later. Each lasts one cycle per sampled strobe. This decoder applies no back-pressure: the surrounding slave logic holds the strobe for as long as it needs the decision.

Top module: `vme_window_decoder`

## Requirements
- R1: After reset, every configuration register reads 0x00 and `mem_sel` and `prot_viol` are low. No access is claimed until the registers are written.
- R2: `mem_sel` requires address bits 31..28 to equal bits 3..0 of register 0 (page). Bits 7..4 of register 0 ignore writes and always read as zero.
- R3: The interval check uses address bits 27..12, which must be at least the lower bound and at most the upper bound. Bits 11..0 are ignored, so the base of the lower page and the last byte of the upper page both hit.
- R4: The lower bound is {register 1, register 2} and the upper bound is {register 3, register 4}. In each pair the first register compares against address bits 27..20 and the second against bits 19..12.
- R5: When the lower bound exceeds the upper bound, no address asserts `mem_sel` or `prot_viol`.
- R6: Register 5 holds four permission fields, each tied to one address modifier. Bits 1..0 apply to AM 0x09, bits 3..2 to AM 0x0A, bits 5..4 to AM 0x0D and bits 7..6 to AM 0x0E. Any other AM code never asserts either output.
- R7: A field value of 00 or 01 disables its code. A value of 10 permits reads only, and 11 permits reads and writes.
- R8: A write (`acc_write`=1) that hits the window under a read-only field does not assert `mem_sel`. Instead, it raises `prot_viol` for exactly one cycle. The two outputs are never high together.
- R9: Both outputs reflect the access sampled at the previous rising edge. Both are low in any cycle after an edge where `acc_stb` was low.
- R10: Register indices 6 and 7 read as 0x00 and ignore writes. A configuration write takes effect for accesses sampled at the following edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 3 | Configuration register index |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data for `cfg_addr` (combinational) |
| acc_stb | input | 1 | Access strobe; the access is sampled when high |
| acc_addr | input | 32 | VME access address |
| acc_am | input | 6 | VME address modifier code |
| acc_write | input | 1 | 1 = write access, 0 = read access |
| mem_sel | output | 1 | Registered claim of the access by main memory |
| prot_viol | output | 1 | Registered one-cycle write-protection violation |

## Verification
The bench probes both edges of the window: the base of the lower page, the last byte of the upper page, and the 4 KB pages just outside each bound. An off-by-one comparator, or one that wrongly decodes bits 11..0, would then accept or reject the wrong one. It loads a lower bound above the upper bound; a design that wraps the interval or tests only one side would claim those addresses. It tries each AM code against each permission value, including the disabled value 01 and an unlisted code, which exposes swapped field positions and a rule that lets bit 0 alone enable a code. It also writes under a read-only code: a faulty design would claim the access, stretch the violation pulse, or miss it. Finally it checks that the page register masks its upper nibble and that unused register indices absorb writes.

// File: rtl/vwd_pkg.sv
package vwd_pkg;
  localparam int ADDR_W  = 32;
  localparam int PAGE_W  = 4;
  localparam int GRAN_W  = 12;
  localparam int BOUND_W = ADDR_W - PAGE_W - GRAN_W;
  localparam int REG_W   = 8;
  localparam int AM_W    = 6;
  localparam int NUM_AM  = 4;
  localparam int PERM_W  = 2;

  typedef enum logic [PERM_W-1:0] {
    PERM_OFF_A = 2'b00,
    PERM_OFF_B = 2'b01,
    PERM_RD    = 2'b10,
    PERM_RW    = 2'b11
  } perm_e;

  // Field i of the permission register qualifies this modifier code.
  function automatic logic [AM_W-1:0] am_code(input int idx);
    case (idx)
      0:       am_code = 6'h09;
      1:       am_code = 6'h0A;
      2:       am_code = 6'h0D;
      3:       am_code = 6'h0E;
      default: am_code = 6'h3F;
    endcase
  endfunction
endpackage

// File: rtl/vwd_cfg_regs.sv
module vwd_cfg_regs
  import vwd_pkg::*;
#(
  parameter int CFG_AW   = 3,
  parameter int NUM_REGS = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [CFG_AW-1:0]    addr,
  input  logic [REG_W-1:0]     wdata,
  output logic [REG_W-1:0]     rdata,
  output logic [PAGE_W-1:0]    page_o,
  output logic [BOUND_W-1:0]   bot_o,
  output logic [BOUND_W-1:0]   top_o,
  output logic [REG_W-1:0]     perm_o
);
  localparam logic [REG_W-1:0] PAGE_MASK = REG_W'((1 << PAGE_W) - 1);

  logic [REG_W-1:0] regs_q [NUM_REGS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= '0;
    end else if (we) begin
      for (int i = 0; i < NUM_REGS; i++) begin
        if (addr == CFG_AW'(i))
          regs_q[i] <= (i == 0) ? (wdata & PAGE_MASK) : wdata;
      end
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (addr == CFG_AW'(i)) rdata = regs_q[i];
  end

  logic [REG_W-1:0] unused_page_hi;
  assign unused_page_hi = regs_q[0] & ~PAGE_MASK;

  assign page_o = regs_q[0][PAGE_W-1:0];
  assign bot_o  = {regs_q[1], regs_q[2]};
  assign top_o  = {regs_q[3], regs_q[4]};
  assign perm_o = regs_q[5];
endmodule

// File: rtl/vwd_range_cmp.sv
module vwd_range_cmp
  import vwd_pkg::*;
(
  input  logic [ADDR_W-1:GRAN_W] addr_hi,
  input  logic [PAGE_W-1:0]      page,
  input  logic [BOUND_W-1:0]     bot,
  input  logic [BOUND_W-1:0]     top,
  output logic                   in_win
);
  logic [PAGE_W-1:0]  a_page;
  logic [BOUND_W-1:0] a_frame;
  logic page_ok, above_bot, below_top;

  assign a_page    = addr_hi[ADDR_W-1 -: PAGE_W];
  assign a_frame   = addr_hi[GRAN_W +: BOUND_W];
  assign page_ok   = (a_page == page);
  assign above_bot = (a_frame >= bot);
  assign below_top = (a_frame <= top);
  assign in_win    = page_ok & above_bot & below_top;
endmodule

// File: rtl/vwd_am_qual.sv
module vwd_am_qual
  import vwd_pkg::*;
(
  input  logic [AM_W-1:0]  am,
  input  logic [REG_W-1:0] perm,
  output logic             rd_ok,
  output logic             wr_ok
);
  logic [NUM_AM-1:0] hit, rd_vec, wr_vec;

  for (genvar g = 0; g < NUM_AM; g++) begin : g_code
    perm_e fld;
    assign fld       = perm_e'(perm[g*PERM_W +: PERM_W]);
    assign hit[g]    = (am == am_code(g));
    assign rd_vec[g] = hit[g] & ((fld == PERM_RD) | (fld == PERM_RW));
    assign wr_vec[g] = hit[g] & (fld == PERM_RW);
  end

  assign rd_ok = |rd_vec;
  assign wr_ok = |wr_vec;
endmodule

// File: rtl/vme_window_decoder.sv
module vme_window_decoder
  import vwd_pkg::*;
#(
  parameter int CFG_AW = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [REG_W-1:0]  cfg_rdata,
  input  logic              acc_stb,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [AM_W-1:0]   acc_am,
  input  logic              acc_write,
  output logic              mem_sel,
  output logic              prot_viol
);
  logic [PAGE_W-1:0]  page_w;
  logic [BOUND_W-1:0] bot_w, top_w;
  logic [REG_W-1:0]   perm_w;
  logic in_win, rd_ok, wr_ok, sel_d, viol_d;
  logic unused_low;

  assign unused_low = ^acc_addr[GRAN_W-1:0];

  vwd_cfg_regs #(.CFG_AW(CFG_AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .rdata(cfg_rdata),
    .page_o(page_w), .bot_o(bot_w), .top_o(top_w), .perm_o(perm_w)
  );

  vwd_range_cmp u_range (
    .addr_hi(acc_addr[ADDR_W-1:GRAN_W]), .page(page_w),
    .bot(bot_w), .top(top_w), .in_win(in_win)
  );

  vwd_am_qual u_am (
    .am(acc_am), .perm(perm_w), .rd_ok(rd_ok), .wr_ok(wr_ok)
  );

  assign sel_d  = acc_stb & in_win & rd_ok & (~acc_write | wr_ok);
  assign viol_d = acc_stb & in_win & rd_ok & acc_write & ~wr_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_sel   <= 1'b0;
      prot_viol <= 1'b0;
    end else begin
      mem_sel   <= sel_d;
      prot_viol <= viol_d;
    end
  end
endmodule

// File: rtl/vwd_checker.sv
module vwd_checker
  import vwd_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               acc_stb,
  input logic [ADDR_W-1:0]  acc_addr,
  input logic [AM_W-1:0]    acc_am,
  input logic               acc_write,
  input logic               mem_sel,
  input logic               prot_viol,
  input logic [PAGE_W-1:0]  page_q,
  input logic [BOUND_W-1:0] bot_q,
  input logic [BOUND_W-1:0] top_q
);
  logic am_listed;
  assign am_listed = (acc_am == 6'h09) | (acc_am == 6'h0A) |
                     (acc_am == 6'h0D) | (acc_am == 6'h0E);

  p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_sel && prot_viol));

  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_stb |=> (!mem_sel && !prot_viol));

  p_page_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_stb && acc_addr[ADDR_W-1 -: PAGE_W] != page_q) |=> !mem_sel);

  p_inverted_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_stb && bot_q > top_q) |=> (!mem_sel && !prot_viol));

  p_am_other_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_stb && !am_listed) |=> (!mem_sel && !prot_viol));

  p_viol_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_stb && !acc_write) |=> !prot_viol);

  p_below_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_stb && acc_addr[GRAN_W +: BOUND_W] < bot_q) |=> !mem_sel);
endmodule

bind vme_window_decoder vwd_checker u_chk (
  .clk(clk), .rst_n(rst_n), .acc_stb(acc_stb), .acc_addr(acc_addr),
  .acc_am(acc_am), .acc_write(acc_write), .mem_sel(mem_sel),
  .prot_viol(prot_viol), .page_q(page_w), .bot_q(bot_w), .top_q(top_w)
);

// File: tb/tb_vme_window_decoder.sv
module tb_vme_window_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic        acc_stb = 1'b0;
  logic [31:0] acc_addr = '0;
  logic [5:0]  acc_am = '0;
  logic        acc_write = 1'b0;
  logic        mem_sel, prot_viol;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  typedef struct { logic s; logic v; string tag; } exp_t;
  exp_t q[$];

  // Shadow configuration, written from the requirements.
  logic [7:0] sh [8];

  always #4 clk = ~clk;

  vme_window_decoder dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .acc_stb(acc_stb),
    .acc_addr(acc_addr), .acc_am(acc_am), .acc_write(acc_write),
    .mem_sel(mem_sel), .prot_viol(prot_viol)
  );

  function automatic void model(input logic [31:0] a, input logic [5:0] am,
                                input logic wr, output logic s, output logic v);
    logic [15:0] frame, bot, top;
    logic [1:0]  f;
    logic        hit;
    frame = a[27:12];
    bot   = {sh[1], sh[2]};
    top   = {sh[3], sh[4]};
    hit   = (a[31:28] == sh[0][3:0]) && (frame >= bot) && (frame <= top);
    case (am)
      6'h09: f = sh[5][1:0];
      6'h0A: f = sh[5][3:2];
      6'h0D: f = sh[5][5:4];
      6'h0E: f = sh[5][7:6];
      default: f = 2'b00;
    endcase
    s = hit && f[1] && (!wr || f[0]);
    v = hit && wr && (f == 2'b10);
  endfunction

  task automatic push(input logic s, input logic v, input string tag);
    exp_t e;
    e.s = s; e.v = v; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(input string tag);
    @(negedge clk);
    cfg_we = 1'b0; acc_stb = 1'b0;
    push(1'b0, 1'b0, tag);
  endtask

  task automatic cfg_write(input int idx, input logic [7:0] d);
    @(negedge clk);
    acc_stb = 1'b0; cfg_we = 1'b1; cfg_addr = 3'(idx); cfg_wdata = d;
    push(1'b0, 1'b0, "R10 cfg");
    if (idx < 6) sh[idx] = (idx == 0) ? (d & 8'h0F) : d;
  endtask

  task automatic rd_check(input int idx, input logic [7:0] exp, input string tag);
    @(negedge clk);
    acc_stb = 1'b0; cfg_we = 1'b0; cfg_addr = 3'(idx);
    push(1'b0, 1'b0, tag);
    #1;
    checks++;
    if (cfg_rdata !== exp) begin
      errors++;
      $display("FAIL %s: reg %0d actual=%h expected=%h", tag, idx, cfg_rdata, exp);
    end
  endtask

  task automatic access(input logic [31:0] a, input logic [5:0] am,
                        input logic wr, input string tag);
    logic s, v;
    @(negedge clk);
    cfg_we = 1'b0; acc_stb = 1'b1; acc_addr = a; acc_am = am; acc_write = wr;
    model(a, am, wr, s, v);
    push(s, v, tag);
  endtask

  // Monitor: each queued item is due just after the next rising edge.
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (mem_sel !== e.s || prot_viol !== e.v) begin
        errors++;
        $display("FAIL %s: actual sel=%b viol=%b expected sel=%b viol=%b",
                 e.tag, mem_sel, prot_viol, e.s, e.v);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) sh[i] = 8'h00;
    repeat (3) @(negedge clk);
    checks++;
    if (mem_sel !== 1'b0 || prot_viol !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset outputs: actual=%b%b expected=00", mem_sel, prot_viol);
    end
    rst_n = 1'b1;
    for (int i = 0; i < 8; i++) rd_check(i, 8'h00, "R1 reset regs");
    access(32'h0000_0000, 6'h09, 1'b0, "R1 closed after reset");
    access(32'h0000_0000, 6'h0E, 1'b1, "R1 closed after reset");

    // Configure: page 5, bounds 0x0100..0x01FF, fields SP=11 SD=10 UP=01 UD=11.
    cfg_write(0, 8'hF5);
    rd_check(0, 8'h05, "R2 page upper nibble");
    cfg_write(1, 8'h01); cfg_write(2, 8'h00);
    cfg_write(3, 8'h01); cfg_write(4, 8'hFF);
    cfg_write(5, 8'hE7);
    rd_check(5, 8'hE7, "R6 perm readback");

    access(32'h5010_0000, 6'h09, 1'b0, "R3 bottom base");
    access(32'h501F_FFFF, 6'h09, 1'b1, "R3 top last byte R7 rw");
    access(32'h500F_FFFF, 6'h09, 1'b0, "R3 below bottom");
    access(32'h5020_0000, 6'h09, 1'b0, "R3 above top");
    access(32'h5015_0ABC, 6'h09, 1'b0, "R3 low bits ignored");
    access(32'h6010_0000, 6'h09, 1'b0, "R2 wrong page");
    access(32'h4015_0000, 6'h09, 1'b0, "R2 wrong page");
    access(32'h5012_0000, 6'h0A, 1'b0, "R7 code 01 disabled");
    access(32'h5012_0000, 6'h0D, 1'b0, "R7 read-only read");
    access(32'h5012_0000, 6'h0D, 1'b1, "R8 read-only write");
    idle("R8 single pulse");
    access(32'h5012_0000, 6'h0E, 1'b1, "R6 supervisor program rw");
    access(32'h5012_0000, 6'h3D, 1'b0, "R6 unlisted code");
    access(32'h5012_0000, 6'h0B, 1'b1, "R6 unlisted code");
    @(negedge clk);
    acc_stb = 1'b0; acc_addr = 32'h5012_0000; acc_am = 6'h09; acc_write = 1'b0;
    push(1'b0, 1'b0, "R9 strobe low");

    // Field position swaps: SP=10 SD=11 UP=10 UD=00.
    cfg_write(5, 8'hB8);
    access(32'h5012_0000, 6'h09, 1'b0, "R7 code 00 disabled");
    access(32'h5012_0000, 6'h0A, 1'b1, "R8 user program read-only write");
    access(32'h5012_0000, 6'h0A, 1'b0, "R6 user program read");
    access(32'h5012_0000, 6'h0D, 1'b1, "R6 supervisor data rw");
    access(32'h5012_0000, 6'h0E, 1'b1, "R8 supervisor program read-only");
    cfg_write(5, 8'hE7);

    // Lower byte of the bottom bound only.
    cfg_write(2, 8'h80);
    access(32'h5017_F000, 6'h09, 1'b0, "R4 below low byte");
    access(32'h5018_0000, 6'h09, 1'b0, "R4 at low byte");
    cfg_write(4, 8'h90);
    access(32'h5019_0FFF, 6'h09, 1'b0, "R4 top low byte");
    access(32'h5019_1000, 6'h09, 1'b0, "R4 above top low byte");

    // Inverted bounds.
    cfg_write(1, 8'h02);
    access(32'h5018_8000, 6'h09, 1'b0, "R5 inverted");
    access(32'h5028_0000, 6'h09, 1'b0, "R5 inverted");
    access(32'h5010_0000, 6'h0D, 1'b1, "R5 inverted no viol");

    // Unused indices.
    cfg_write(6, 8'hFF);
    cfg_write(7, 8'hAA);
    rd_check(6, 8'h00, "R10 index 6");
    rd_check(7, 8'h00, "R10 index 7");
    rd_check(5, 8'hE7, "R10 perm untouched");
    rd_check(1, 8'h02, "R4 bottom upper");

    idle("end");
    idle("end");
    @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule